// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load-Use Interlock

This block is the interlock and bypass controller of a five-stage in-order pipeline whose operands are resolved in the decode stage. Each cycle it is given the two source register numbers of the instruction being decoded, along with that instruction's own destination number, register-write bit and load bit. It also receives a redirect pulse when the decoded instruction is a jump or a taken branch. The block keeps its own copy of the destination number and write/load control bits for the execute, memory and write-back stages. From that copy it produces one 2-bit operand-select code for each source.

It also raises a stall that freezes the PC and instruction register when a value being loaded is needed one cycle too early. It raises a bubble whenever the control bits entering execute must be cleared. This happens on a stall and for the single instruction already fetched behind a jump or taken branch. The register file, ALU, memories and the operand multiplexers themselves sit outside the block.

Top module: `fsu_hazard_unit`

## Requirements
- R1: After reset, every tracked stage has its write and load bits cleared. Until a decoded instruction with its write bit set has moved into execute, both selects read 0 and stall and bubble are 0.
- R2: Each select code means: 0 = register-file value, 1 = result of the instruction in execute, 2 = memory stage, 3 = write-back stage. A stage is a candidate only if its tracked destination equals the source number and its tracked write bit is 1.
- R3: When several stages are candidates, the select picks execute over memory, and memory over write-back.
- R4: A source number of 0 always yields select 0, whatever the stages hold.
- R5: `stall` is 1 exactly when the instruction in execute is a load and at least one select equals 1. The one exception is the case covered by R8.
- R6: In a cycle with `bubble` = 1, the decoded instruction's write and load bits do not enter execute. Its destination number does enter.
- R7: After a one-cycle load-use stall, the held instruction is evaluated again. Its select for the loaded register is then 2, and `stall` is 0.
- R8: In the cycle after a `redirect` is accepted, the decoded instruction is squashed. `bubble` is 1, `stall` is 0, and its own `redirect` is ignored. A `redirect` is accepted only when `stall` is 0 and the instruction is not itself squashed.
- R9: `bubble` is 1 exactly when `stall` is 1 or the decoded instruction is squashed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_src_a | input | REG_AW | First source register of the decoded instruction |
| dec_src_b | input | REG_AW | Second source register of the decoded instruction |
| dec_dst | input | REG_AW | Destination register of the decoded instruction |
| dec_wr | input | 1 | Decoded instruction writes a register |
| dec_ld | input | 1 | Decoded instruction is a load |
| redirect | input | 1 | Decoded instruction is a jump or taken branch |
| fwd_a | output | 2 | Select code for the first operand |
| fwd_b | output | 2 | Select code for the second operand |
| stall | output | 1 | Hold PC and instruction register |
| bubble | output | 1 | Clear control bits entering execute |

## Verification
The bench targets four corner cases:
- The same register written by all three stages at once. A wrong priority order would hand an older value to the operand.
- Producers whose write bit is off, and register 0 as a source. A design that got these wrong would forward from instructions that write nothing.
- The cycle right after a load-use stall. A design that fails to clear the execute control bits would stall forever, or pick code 1 instead of 2.
- The squashed slot behind a redirect. A leaky design would let that slot's write bit or its own redirect take effect, or let it stall.

Random streams over a small register range keep these collisions frequent.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'd0,
      SEL_EX  = 2'd1,
      SEL_MEM = 2'd2,
      SEL_WB  = 2'd3
   } opsel_e;

   localparam int STAGES = 3;
   localparam int ST_EX  = 0;
   localparam int ST_MEM = 1;
   localparam int ST_WB  = 2;
endpackage

// File: rtl/fsu_ctrl_pipe.sv
module fsu_ctrl_pipe #(
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bubble,
   input  logic [REG_AW-1:0] in_dst,
   input  logic              in_wr,
   input  logic              in_ld,
   output logic [REG_AW-1:0] st_dst [fsu_pkg::STAGES],
   output logic              st_wr  [fsu_pkg::STAGES],
   output logic              ex_ld
);
   import fsu_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_dst[ST_EX] <= '0;
         st_wr[ST_EX]  <= 1'b0;
         ex_ld         <= 1'b0;
      end else begin
         st_dst[ST_EX] <= in_dst;
         st_wr[ST_EX]  <= in_wr & ~bubble;
         ex_ld         <= in_ld & ~bubble;
      end
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_dst[s] <= '0;
            st_wr[s]  <= 1'b0;
         end else begin
            st_dst[s] <= st_dst[s-1];
            st_wr[s]  <= st_wr[s-1];
         end
      end
   end

   AST_BUBBLE_CLEARS_EX: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> (!st_wr[ST_EX] && !ex_ld)); // R6
   AST_MEM_TRACKS_EX: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr[ST_EX] |=> st_wr[ST_MEM]); // R2
endmodule

// File: rtl/fsu_src_match.sv
module fsu_src_match #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] st_dst [fsu_pkg::STAGES],
   input  logic              st_wr  [fsu_pkg::STAGES],
   output fsu_pkg::opsel_e   sel
);
   import fsu_pkg::*;

   logic [STAGES-1:0] hit;

   for (genvar s = 0; s < STAGES; s++) begin : g_hit
      assign hit[s] = st_wr[s] && (st_dst[s] == src) && (src != '0);
   end

   always_comb begin
      if (hit[ST_EX])       sel = SEL_EX;
      else if (hit[ST_MEM]) sel = SEL_MEM;
      else if (hit[ST_WB])  sel = SEL_WB;
      else                  sel = SEL_RF;
   end

   always_comb begin
      AST_ZERO_SRC_NO_FWD: assert (src != '0 || sel == SEL_RF); // R4
      AST_SEL_HAS_WRITER: assert (sel == SEL_RF || st_wr[int'(sel) - 1]); // R2
   end
endmodule

// File: rtl/fsu_hold_ctl.sv
module fsu_hold_ctl (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_ld,
   input  fsu_pkg::opsel_e sel_a,
   input  fsu_pkg::opsel_e sel_b,
   input  logic            redirect,
   output logic            stall,
   output logic            bubble
);
   import fsu_pkg::*;

   logic squash_q;
   logic take_redirect;

   assign stall         = ex_ld && (sel_a == SEL_EX || sel_b == SEL_EX) && !squash_q;
   assign bubble        = stall || squash_q;
   assign take_redirect = redirect && !stall && !squash_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) squash_q <= 1'b0;
      else        squash_q <= take_redirect;
   end

   AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ex_ld); // R5
   AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall); // R7
   AST_REDIRECT_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && !bubble) |=> (bubble && !stall)); // R8
endmodule

// File: rtl/fsu_hazard_unit.sv
module fsu_hazard_unit #(
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] dec_src_a,
   input  logic [REG_AW-1:0] dec_src_b,
   input  logic [REG_AW-1:0] dec_dst,
   input  logic              dec_wr,
   input  logic              dec_ld,
   input  logic              redirect,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic              stall,
   output logic              bubble
);
   import fsu_pkg::*;

   localparam int NSRC  = 2;
   localparam int NREGS = 1 << REG_AW;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("REG_AW out of range");
   end
   if (NREGS < 2) begin : g_bad_regs
      $error("need at least two registers");
   end

   logic [REG_AW-1:0] st_dst [STAGES];
   logic              st_wr  [STAGES];
   logic              ex_ld;
   logic [REG_AW-1:0] src    [NSRC];
   opsel_e            sel    [NSRC];

   assign src[0] = dec_src_a;
   assign src[1] = dec_src_b;

   fsu_ctrl_pipe #(.REG_AW(REG_AW)) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .bubble (bubble),
      .in_dst (dec_dst),
      .in_wr  (dec_wr),
      .in_ld  (dec_ld),
      .st_dst (st_dst),
      .st_wr  (st_wr),
      .ex_ld  (ex_ld)
   );

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      fsu_src_match #(.REG_AW(REG_AW)) u_match (
         .src    (src[k]),
         .st_dst (st_dst),
         .st_wr  (st_wr),
         .sel    (sel[k])
      );
   end

   fsu_hold_ctl u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .ex_ld    (ex_ld),
      .sel_a    (sel[0]),
      .sel_b    (sel[1]),
      .redirect (redirect),
      .stall    (stall),
      .bubble   (bubble)
   );

   assign fwd_a = sel[0];
   assign fwd_b = sel[1];

   AST_BUBBLE_COVERS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> bubble); // R9
endmodule

// File: tb/fsu_hazard_unit_tb.sv
module fsu_hazard_unit_tb;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] src_a = '0, src_b = '0, dst = '0;
   logic wr = 1'b0, ld = 1'b0, redir = 1'b0;
   logic [1:0] fwd_a, fwd_b;
   logic stall, bubble;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // reference state
   logic [AW-1:0] m_dst [3];
   logic          m_wr  [3];
   logic          m_ld, m_kill;
   logic [1:0]    e_a, e_b;
   logic          e_stall, e_bub;

   always #2 clk = ~clk;

   fsu_hazard_unit #(.REG_AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .dec_src_a(src_a), .dec_src_b(src_b),
      .dec_dst(dst), .dec_wr(wr), .dec_ld(ld), .redirect(redir),
      .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble));

   function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
      if (s == '0) return 2'd0;
      for (int i = 0; i < 3; i++)
         if (m_wr[i] && m_dst[i] == s) return 2'(i + 1);
      return 2'd0;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 3; i++) begin m_dst[i] = '0; m_wr[i] = 1'b0; end
      m_ld = 1'b0; m_kill = 1'b0;
   endtask

   // one decode cycle: drive, compare, advance the model at the edge
   task automatic cyc(input logic [AW-1:0] a, input logic [AW-1:0] b,
                      input logic [AW-1:0] d, input logic w, input logic l,
                      input logic r, input string tag);
      @(negedge clk);
      src_a = a; src_b = b; dst = d; wr = w; ld = l; redir = r;
      #1;
      e_a = exp_sel(a);
      e_b = exp_sel(b);
      e_stall = m_ld && (e_a == 2'd1 || e_b == 2'd1) && !m_kill;
      e_bub = e_stall || m_kill;
      chk(tag, "fwd_a", fwd_a, e_a);
      chk(tag, "fwd_b", fwd_b, e_b);
      chk(tag, "stall", stall, e_stall);
      chk(tag, "bubble", bubble, e_bub);
      @(posedge clk);
      m_dst[2] = m_dst[1]; m_wr[2] = m_wr[1];
      m_dst[1] = m_dst[0]; m_wr[1] = m_wr[0];
      m_dst[0] = d; m_wr[0] = w && !e_bub; m_ld = l && !e_bub;
      m_kill = r && !e_stall && !m_kill;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state: nothing tracked yet
      cyc(5, 6, 0, 1'b0, 1'b0, 1'b0, "R1");
      cyc(5, 6, 0, 1'b0, 1'b0, 1'b0, "R1");
      // R2 producer without write bit never forwards
      cyc(1, 1, 3, 1'b0, 1'b0, 1'b0, "R2");
      cyc(3, 3, 0, 1'b0, 1'b0, 1'b0, "R2");
      // R3 priority: three writers of register 4
      cyc(0, 0, 4, 1'b1, 1'b0, 1'b0, "R3");
      cyc(0, 0, 4, 1'b1, 1'b0, 1'b0, "R3");
      cyc(0, 0, 4, 1'b1, 1'b0, 1'b0, "R3");
      cyc(4, 4, 0, 1'b0, 1'b0, 1'b0, "R3"); // expect 1
      cyc(4, 0, 0, 1'b0, 1'b0, 1'b0, "R3"); // expect 2
      cyc(0, 4, 0, 1'b0, 1'b0, 1'b0, "R3"); // expect 3
      // R4 register 0 writers are ignored as sources
      cyc(0, 0, 0, 1'b1, 1'b0, 1'b0, "R4");
      cyc(0, 0, 0, 1'b1, 1'b0, 1'b0, "R4");
      cyc(0, 0, 0, 1'b0, 1'b0, 1'b0, "R4");
      // R5 load-use stall, R6 bubble, R7 retry picks memory stage
      cyc(0, 0, 7, 1'b1, 1'b1, 1'b0, "R5");
      cyc(2, 7, 9, 1'b1, 1'b0, 1'b0, "R5"); // stall, bubble
      cyc(2, 7, 9, 1'b1, 1'b0, 1'b0, "R7"); // fwd_b 2, no stall
      cyc(9, 9, 0, 1'b0, 1'b0, 1'b0, "R6"); // retried instr now in EX
      // R8 squash behind redirect, R9 bubble
      cyc(0, 0, 12, 1'b1, 1'b1, 1'b0, "R8");
      cyc(1, 2, 0, 1'b0, 1'b0, 1'b1, "R8");
      cyc(12, 12, 11, 1'b1, 1'b1, 1'b1, "R8"); // squashed slot
      cyc(11, 11, 0, 1'b0, 1'b0, 1'b0, "R9"); // its writes must not show
      cyc(0, 0, 0, 1'b0, 1'b0, 1'b0, "R9");
      // random mix over a small register range
      for (int n = 0; n < 4000; n++) begin
         cyc(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
             AW'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0),
             1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 7) == 0),
             "R2_R3_R5_R9");
      end
      // reset mid-stream clears tracked state (R1)
      @(negedge clk); rst_n = 1'b0;
      model_reset();
      @(negedge clk); rst_n = 1'b1;
      cyc(1, 2, 0, 1'b0, 1'b0, 1'b0, "R1");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule